// File: doc/BRIEF.md
# Multi-Peripheral Reset Sequencer

This block runs the power-up initialization phase of a small system with three optional peripherals: a DAC, an ADC and an Ethernet controller. It holds its own 3-bit phase counter. When the counter reads zero, the block sends one single-cycle start pulse to the initializer of each peripheral whose enable input is high. It then watches the done levels that come back. Each initializer drops its done level when its start arrives and raises it again when it has finished.

When every enabled peripheral reports done, the block emits one single-cycle completion pulse. That pulse advances the phase counter from 000 to 001, which ends the reset phase for the rest of the system. A disabled peripheral gets no start pulse, and its done level is left out of the completion condition. All outputs come straight from registers.

Top module: `rsq_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, `state_o` is 000 and `start_o` and `complete_o` are 0. This holds at once, without waiting for a clock edge.
- R2: Entering phase 000 gives exactly one common start, one cycle long. After reset is released, `start_o` is valid in the cycle that follows the first rising clock edge, and it is zero in every later cycle.
- R3: `start_o[i]` is the common start ANDed with `en_i[i]`. Bit 0 is the DAC, bit 1 is the ADC and bit 2 is the Ethernet controller.
- R4: The done level of a disabled channel has no effect. This holds even when that level is held low forever: completion timing then depends only on the enabled channels.
- R5: `complete_o` rises one cycle after the last enabled done level has risen. It stays high for exactly one cycle.
- R6: With no channel enabled, `complete_o` still follows the start. It is high in the third cycle after reset release, counting the start cycle as the first.
- R7: Done levels are only sampled from the cycle after the start pulse onward. A done level that is already high before the start therefore cannot cause an early completion.
- R8: `state_o` increments by one on the clock edge that ends a `complete_o` cycle, so it goes from 000 to 001. At every other edge it holds its value.
- R9: Each entry into phase 000 gives exactly one completion pulse. After the counter leaves 000, no further start or completion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 3 | Per-channel enable, static during a run (bit 0 DAC, 1 ADC, 2 Ethernet) |
| done_i | input | 3 | Per-channel done level from the initializers |
| start_o | output | 3 | Per-channel single-cycle start pulse |
| complete_o | output | 1 | Single-cycle pulse when all enabled channels are done |
| state_o | output | 3 | Phase counter value |

## Verification
The bench counts the rising edges after reset release and samples each result at the following falling edge.

| Result | Due after edge n = |
|---|---|
| `start_o` | 1 |
| `complete_o` | 3 + M |
| `state_o` reads 001 | 4 + M and later |

Here M is the largest responder delay among the enabled channels, or 0 if none is enabled. Each modelled responder drops its done level at edge 2 and raises it again at edge 2 + its delay.

Every cycle of a 30-cycle window is compared against these predictions. This catches early, late, repeated and missing pulses. Preset-high done levels and disabled channels held low show that only the enabled done levels are sampled, and only after the start.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  // Number of peripheral channels; bit order: 0 DAC, 1 ADC, 2 Ethernet
  localparam int unsigned RSQ_NCH = 3;
  // Width of the phase counter
  localparam int unsigned RSQ_SW  = 3;
endpackage

// File: rtl/rsq_launch.sv
`timescale 1ns/1ps
module rsq_launch #(
  parameter int unsigned NCH = 3,
  parameter int unsigned SW  = 3,
  parameter logic [SW-1:0] RUN_STATE = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  state_i,
  input  logic [NCH-1:0] en_i,
  output logic           go_o,
  output logic [NCH-1:0] start_o
);
  logic stage_en;
  logic stage_q;
  logic go_q;
  logic [NCH-1:0] start_q;

  // Stage is active only when the phase counter sits at the run state
  assign stage_en = (state_i == RUN_STATE);

  // stage_q clears on reset, so leaving reset in the run state gives one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      go_q    <= 1'b0;
      start_q <= '0;
    end else begin
      stage_q <= stage_en;
      go_q    <= stage_en & ~stage_q;
      start_q <= {NCH{stage_en & ~stage_q}} & en_i;
    end
  end

  assign go_o    = go_q;
  assign start_o = start_q;

  p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);
  p_start_follows_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q != '0) |-> go_q);
endmodule

// File: rtl/rsq_gather.sv
`timescale 1ns/1ps
module rsq_gather #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] done_i,
  output logic           complete_o
);
  logic [NCH-1:0] chan_ok;
  logic ready;
  logic armed_q;
  logic cond_q;
  logic cmp_q;
  logic cond_arm;

  // A channel counts as finished when it is done or when it is disabled
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_mask
      assign chan_ok[g] = done_i[g] | ~en_i[g];
    end
  endgenerate

  assign ready    = &chan_ok;
  assign cond_arm = armed_q & ready;

  // armed_q opens the sampling window one cycle after the common start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cond_q  <= 1'b0;
      cmp_q   <= 1'b0;
    end else begin
      if (go_i)
        armed_q <= 1'b1;
      else if (cond_arm & ~cond_q)
        armed_q <= 1'b0;
      cond_q <= cond_arm;
      cmp_q  <= cond_arm & ~cond_q;
    end
  end

  assign complete_o = cmp_q;

  p_complete_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q |=> !cmp_q);
  p_complete_needs_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q |-> $past(armed_q));
  p_no_complete_with_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !cmp_q);
endmodule

// File: rtl/rsq_phase_ctr.sv
`timescale 1ns/1ps
module rsq_phase_ctr #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [SW-1:0] state_o
);
  logic [SW-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= '0;
    else if (adv_i)
      state_q <= state_q + SW'(1);
  end

  assign state_o = state_q;

  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));
  p_state_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (state_q == $past(state_q) + SW'(1)));
endmodule

// File: rtl/rsq_reset_sequencer.sv
`timescale 1ns/1ps
module rsq_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int unsigned NCH = RSQ_NCH,
  parameter int unsigned SW  = RSQ_SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] done_i,
  output logic [NCH-1:0] start_o,
  output logic           complete_o,
  output logic [SW-1:0]  state_o
);
  logic [SW-1:0] state_w;
  logic go_w;
  logic cmp_w;

  rsq_phase_ctr #(.SW(SW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (cmp_w),
    .state_o (state_w)
  );

  rsq_launch #(.NCH(NCH), .SW(SW), .RUN_STATE('0)) u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_w),
    .en_i    (en_i),
    .go_o    (go_w),
    .start_o (start_o)
  );

  rsq_gather #(.NCH(NCH)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_w),
    .en_i       (en_i),
    .done_i     (done_i),
    .complete_o (cmp_w)
  );

  assign complete_o = cmp_w;
  assign state_o    = state_w;

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |=> (start_o == '0));
  p_start_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o & ~en_i) == '0);
  p_start_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> (state_o == '0));
  p_one_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != '0) |-> !complete_o);
endmodule

// File: tb/tb_rsq_reset_sequencer.sv
`timescale 1ns/1ps
module tb_rsq_reset_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] en = 3'b000;
  logic [2:0] done;
  logic [2:0] start;
  logic       complete;
  logic [2:0] state;

  int dly [3];
  logic stale = 1'b0;
  int cnt [3];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rsq_reset_sequencer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .done_i     (done),
    .start_o    (start),
    .complete_o (complete),
    .state_o    (state)
  );

  // Delayed done responders: drop on start, rise dly edges later
  for (genvar i = 0; i < 3; i++) begin : g_resp
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done[i] <= stale;
        cnt[i]  <= 0;
      end else if (start[i]) begin
        done[i] <= 1'b0;
        cnt[i]  <= dly[i];
      end else if (cnt[i] > 0) begin
        cnt[i] <= cnt[i] - 1;
        if (cnt[i] == 1)
          done[i] <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_case(input string name, input logic [2:0] e,
                          input int d0, input int d1, input int d2, input logic pre);
    int m;
    m = 0;
    en = e; dly[0] = d0; dly[1] = d1; dly[2] = d2; stale = pre;
    for (int k = 0; k < 3; k++)
      if (e[k] && dly[k] > m) m = dly[k];
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {name, " reset state"}, state, 0);
    check("R1", {name, " reset start"}, start, 0);
    check("R1", {name, " reset complete"}, complete, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      // R2 R3: start only at edge 1, masked by enable
      check("R2/R3", {name, " start"}, start, (n == 1) ? e : 3'b000);
      // R5 R6 R7 R4 R9: completion exactly at edge 3+M
      check("R5", {name, " complete"}, complete, (n == 3 + m) ? 1 : 0);
      // R8: counter steps to 001 at edge 4+M and holds
      check("R8", {name, " state"}, state, (n >= 4 + m) ? 1 : 0);
    end
  endtask

  task automatic async_reset_case();
    en = 3'b111; dly[0] = 5; dly[1] = 5; dly[2] = 5; stale = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "async pre start", start, 3'b111);
    @(negedge clk);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1", "async mid state", state, 0);
    check("R1", "async mid start", start, 0);
    check("R1", "async mid complete", complete, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "restart start", start, 3'b111);
    @(negedge clk);
    check("R2", "restart start gone", start, 3'b000);
  endtask

  initial begin
    run_case("all_en",     3'b111, 3, 5, 2, 1'b0); // R5
    run_case("adc_only",   3'b010, 9, 4, 9, 1'b0); // R3 R4: disabled done held low
    run_case("none_en",    3'b000, 2, 2, 2, 1'b0); // R6
    run_case("stale_high", 3'b101, 6, 1, 3, 1'b1); // R7
    run_case("eth_only",   3'b100, 1, 1, 1, 1'b0); // R9
    async_reset_case();                             // R1
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule